// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This unit settles control flow for a core whose instructions vary in length. A compare opcode checks two operands against each other. The result is a small condition word, which is written into a dedicated flag register on the next clock edge. Conditional branches that come later read that stored word. They do not look at the operands again. The two zero-test branches are the exception: they inspect the first operand directly.

Every cycle the unit produces the address of the next instruction. When a branch is taken, that address is the supplied target. In every other case it is the current program counter plus the decoded length of the current instruction. The unit also reports whether a branch was taken, and it drives a write-back strobe and data word for the flag register. Link, return and interrupt-return handling lie outside this block.

Top module: `branch_resolve_unit`

## Requirements
- R1: On opcode 0x27 the unit raises `cfWrEn` and drives `cfWrData` with bit 0 = operands equal, bit 1 = `opA` less than `opB` as signed values, bit 2 = `opA` less than `opB` as unsigned values, and all higher bits zero. At the next rising clock edge `flagReg` takes that value.
- R2: While `rst` is high at a rising edge, `flagReg` is cleared to zero.
- R3: Opcode 0x26 always asserts `taken` and drives `nextPc` with `target`.
- R4: Opcode 0x28 is taken when `flagReg` bit 0 is set. Opcode 0x29 is taken when that bit is clear.
- R5: Opcode 0x2A is taken when `flagReg` bit 1 is set. Opcode 0x2D is taken when that bit is clear.
- R6: Opcode 0x2B is taken when `flagReg` bits 0 and 1 are both clear. Opcode 0x2C is taken when either bit is set.
- R7: Opcode 0x2E is taken when `opA` is zero, and opcode 0x2F when it is nonzero. Both ignore `flagReg`.
- R8: Whenever `taken` is low, `nextPc` equals `pc + instLen`, wrapping modulo 2^ADDR_W. When `taken` is high, `nextPc` equals `target`.
- R9: Any opcode outside 0x26 to 0x2F keeps `taken` and `cfWrEn` low and leaves `flagReg` unchanged.
- R10: Branch opcodes 0x26 and 0x28 to 0x2F keep `cfWrEn` low and leave `flagReg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode of the current instruction |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| target | input | ADDR_W | Branch destination |
| pc | input | ADDR_W | Address of the current instruction |
| instLen | input | LEN_W | Decoded length of the current instruction |
| nextPc | output | ADDR_W | Address of the next instruction |
| taken | output | 1 | Branch taken this cycle |
| cfWrEn | output | 1 | Flag register write-back strobe |
| cfWrData | output | DATA_W | Flag register write-back value |
| flagReg | output | DATA_W | Current flag register contents |

## Verification
The bench builds the unit with DATA_W = 4, ADDR_W = 8 and LEN_W = 4. With 4-bit operands, all 256 operand pairs can be compared. That includes every point where the signed and unsigned orderings disagree. After each compare, every conditional branch is checked against the stored result. With an 8-bit address and a 4-bit length, the full grid of pc and length values is swept, so every wrap of the fall-through adder is covered. All 256 opcode values are also applied, to confirm that non-branch codes leave the flag register alone.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [7:0] OP_JMP = 8'h26;
  localparam logic [7:0] OP_CMP = 8'h27;
  localparam logic [7:0] OP_BEQ = 8'h28;
  localparam logic [7:0] OP_BNE = 8'h29;
  localparam logic [7:0] OP_BLT = 8'h2A;
  localparam logic [7:0] OP_BGT = 8'h2B;
  localparam logic [7:0] OP_BLE = 8'h2C;
  localparam logic [7:0] OP_BGE = 8'h2D;
  localparam logic [7:0] OP_BZ  = 8'h2E;
  localparam logic [7:0] OP_BNZ = 8'h2F;

  localparam int CF_EQ   = 0;
  localparam int CF_SLT  = 1;
  localparam int CF_ULT  = 2;
  localparam int CF_BITS = 3;

  typedef struct packed {
    logic cfLoad;
    logic redirect;
  } bru_strobe_t;
endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic [7:0]         opcode,
  input  logic [CF_BITS-1:0] cfFlags,
  input  logic               aIsZero,
  output bru_strobe_t        strobe
);
  logic isEq, isLt;

  assign isEq = cfFlags[CF_EQ];
  assign isLt = cfFlags[CF_SLT];

  always_comb begin
    strobe = '0;
    unique case (opcode)
      OP_JMP:  strobe.redirect = 1'b1;
      OP_CMP:  strobe.cfLoad   = 1'b1;
      OP_BEQ:  strobe.redirect = isEq;
      OP_BNE:  strobe.redirect = ~isEq;
      OP_BLT:  strobe.redirect = isLt;
      OP_BGT:  strobe.redirect = ~isEq & ~isLt;
      OP_BLE:  strobe.redirect = isEq | isLt;
      OP_BGE:  strobe.redirect = ~isLt;
      OP_BZ:   strobe.redirect = aIsZero;
      OP_BNZ:  strobe.redirect = ~aIsZero;
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/bru_datapath.sv
module bru_datapath
  import bru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  bru_strobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic [DATA_W-1:0] cfNext,
  output logic [DATA_W-1:0] cfQ,
  output logic              aIsZero
);
  localparam int PAD_W = DATA_W - CF_BITS;

  logic [CF_BITS-1:0] relBits;
  logic [ADDR_W-1:0]  fallPc;

  always_comb begin
    relBits         = '0;
    relBits[CF_EQ]  = (opA == opB);
    relBits[CF_SLT] = ($signed(opA) < $signed(opB));
    relBits[CF_ULT] = (opA < opB);
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign cfNext = {{PAD_W{1'b0}}, relBits};
    end else begin : g_nopad
      assign cfNext = relBits;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                cfQ <= '0;
    else if (strobe.cfLoad) cfQ <= cfNext;
  end

  assign aIsZero = (opA == '0);
  assign fallPc  = pc + ADDR_W'(instLen);
  assign nextPc  = strobe.redirect ? target : fallPc;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic              cfWrEn,
  output logic [DATA_W-1:0] cfWrData,
  output logic [DATA_W-1:0] flagReg
);
  bru_strobe_t strobe;
  logic        aIsZero;

  bru_ctrl u_ctrl (
    .opcode  (opcode),
    .cfFlags (flagReg[CF_BITS-1:0]),
    .aIsZero (aIsZero),
    .strobe  (strobe)
  );

  bru_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .target  (target),
    .pc      (pc),
    .instLen (instLen),
    .nextPc  (nextPc),
    .cfNext  (cfWrData),
    .cfQ     (flagReg),
    .aIsZero (aIsZero)
  );

  assign taken  = strobe.redirect;
  assign cfWrEn = strobe.cfLoad;
endmodule

// File: rtl/bru_checker.sv
module bru_checker
  import bru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] opA,
  input logic [ADDR_W-1:0] target,
  input logic [ADDR_W-1:0] pc,
  input logic [LEN_W-1:0]  instLen,
  input logic [ADDR_W-1:0] nextPc,
  input logic              taken,
  input logic              cfWrEn,
  input logic [DATA_W-1:0] cfWrData,
  input logic [DATA_W-1:0] flagReg
);
  a_r2_reset_clears: assert property (@(posedge clk) rst |=> flagReg == '0);

  a_r1_cf_loaded: assert property (@(posedge clk) disable iff (rst)
    cfWrEn |=> flagReg == $past(cfWrData));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    cfWrEn |-> (cfWrData >> CF_BITS) == '0);

  a_r9_cf_holds: assert property (@(posedge clk) disable iff (rst)
    !cfWrEn |=> $stable(flagReg));

  a_r3_uncond: assert property (@(posedge clk) disable iff (rst)
    opcode == OP_JMP |-> taken && nextPc == target);

  a_r8_fallthrough: assert property (@(posedge clk) disable iff (rst)
    !taken |-> nextPc == ADDR_W'(pc + ADDR_W'(instLen)));

  a_r7_zero_test: assert property (@(posedge clk) disable iff (rst)
    opcode == OP_BZ |-> taken == (opA == '0));

  a_r10_branch_no_write: assert property (@(posedge clk) disable iff (rst)
    taken |-> !cfWrEn);
endmodule

bind branch_resolve_unit bru_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opcode   (opcode),
  .opA      (opA),
  .target   (target),
  .pc       (pc),
  .instLen  (instLen),
  .nextPc   (nextPc),
  .taken    (taken),
  .cfWrEn   (cfWrEn),
  .cfWrData (cfWrData),
  .flagReg  (flagReg)
);

// File: tb/sim_branch_resolve_unit.sv
module sim_branch_resolve_unit;
  localparam int DW = 4;
  localparam int AW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [7:0]    opcode;
  logic [DW-1:0] opA, opB;
  logic [AW-1:0] target, pc;
  logic [LW-1:0] instLen;
  logic [AW-1:0] nextPc;
  logic          taken, cfWrEn;
  logic [DW-1:0] cfWrData, flagReg;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  branch_resolve_unit #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .opA(opA), .opB(opB),
    .target(target), .pc(pc), .instLen(instLen), .nextPc(nextPc),
    .taken(taken), .cfWrEn(cfWrEn), .cfWrData(cfWrData), .flagReg(flagReg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sval(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  function automatic int expCf(input int a, input int b);
    return ((a == b) ? 1 : 0) | ((sval(a) < sval(b)) ? 2 : 0) | ((a < b) ? 4 : 0);
  endfunction

  function automatic bit expTake(input int op, input int cf);
    bit eq = cf[0];
    bit lt = cf[1];
    case (op)
      8'h28: return eq;
      8'h29: return !eq;
      8'h2A: return lt;
      8'h2B: return !eq && !lt;
      8'h2C: return eq || lt;
      8'h2D: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doCmp(input int a, input int b);
    tick();
    opcode = 8'h27; opA = DW'(a); opB = DW'(b);
    tick();
    opcode = 8'h01;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1; opcode = 8'h01; opA = '0; opB = '0;
    target = '0; pc = '0; instLen = '0;
    repeat (3) tick();
    chk(flagReg == 0, "R2 reset value", flagReg, 0);
    rst = 1'b0;

    // R1 R4 R5 R6 R10: every operand pair, then every flag branch
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int cf;
        cf = expCf(a, b);
        tick();
        opcode = 8'h27; opA = DW'(a); opB = DW'(b);
        pc = AW'(a * 16 + b); instLen = LW'(b); target = 8'hAA;
        #1;
        chk(cfWrEn == 1'b1, "R1 write strobe", cfWrEn, 1);
        chk(cfWrData == DW'(cf), "R1 condition word", cfWrData, cf);
        chk(taken == 1'b0 && nextPc == AW'(a * 16 + 2 * b), "R8 compare falls through", nextPc, AW'(a * 16 + 2 * b));
        tick();
        chk(flagReg == DW'(cf), "R1 flag register load", flagReg, cf);
        for (int op = 8'h28; op <= 8'h2D; op++) begin
          bit e;
          e = expTake(op, cf);
          opcode = 8'(op); opA = DW'(b); opB = DW'(a);
          #1;
          if (op == 8'h28 || op == 8'h29)
            chk(taken == e, "R4 equal branches", taken, e);
          else if (op == 8'h2A || op == 8'h2D)
            chk(taken == e, "R5 less and not-less branches", taken, e);
          else
            chk(taken == e, "R6 greater and less-or-equal branches", taken, e);
          chk(nextPc == (e ? 8'hAA : AW'(pc + AW'(instLen))), "R8 next address", nextPc,
              e ? 8'hAA : AW'(pc + AW'(instLen)));
          chk(cfWrEn == 1'b0, "R10 branch does not write", cfWrEn, 0);
        end
        tick();
        chk(flagReg == DW'(cf), "R10 flag kept after branches", flagReg, cf);
      end
    end

    // R7: zero tests under both flag states
    for (int s = 0; s < 2; s++) begin
      if (s == 0) doCmp(5, 5); else doCmp(1, 2);
      for (int a = 0; a < 16; a++) begin
        opA = DW'(a); target = 8'h3C; pc = 8'h10; instLen = 4'd3;
        opcode = 8'h2E; #1;
        chk(taken == (a == 0), "R7 branch if zero", taken, a == 0);
        opcode = 8'h2F; #1;
        chk(taken == (a != 0), "R7 branch if nonzero", taken, a != 0);
        chk(nextPc == ((a != 0) ? 8'h3C : 8'h13), "R7 nonzero target", nextPc, (a != 0) ? 8'h3C : 8'h13);
      end
    end

    // R3: unconditional branch
    for (int t = 0; t < 256; t += 17) begin
      opcode = 8'h26; target = AW'(t); pc = AW'(255 - t); instLen = 4'd7; #1;
      chk(taken == 1'b1, "R3 always taken", taken, 1);
      chk(nextPc == AW'(t), "R3 target loaded", nextPc, t);
    end

    // R8: full pc by length grid with wrap
    opcode = 8'h01;
    for (int p = 0; p < 256; p++) begin
      for (int l = 0; l < 16; l++) begin
        pc = AW'(p); instLen = LW'(l); #1;
        chk(nextPc == AW'((p + l) % 256), "R8 fall-through wrap", nextPc, (p + l) % 256);
      end
    end

    // R9: every non-branch opcode keeps flags (3 vs 12 -> 4'b0100)
    doCmp(3, 12);
    chk(flagReg == 4'h4, "R1 unsigned only", flagReg, 4);
    for (int op = 0; op < 256; op++) begin
      if (op >= 8'h26 && op <= 8'h2F) continue;
      opcode = 8'(op); opA = 4'd7; opB = 4'd7; #1;
      chk(taken == 1'b0 && cfWrEn == 1'b0, "R9 no branch no write", {taken, cfWrEn}, 0);
      tick();
      chk(flagReg == 4'h4, "R9 flag unchanged", flagReg, 4);
    end

    // R2: reset in mid run
    opcode = 8'h01;
    rst = 1'b1;
    tick();
    chk(flagReg == 0, "R2 reset clears flags", flagReg, 0);
    rst = 1'b0;
    tick();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule